// File: doc/BRIEF.md
# Half-Bridge Interlock and Dead-Time Controller

This block drives the two gate enables of one half-bridge leg from three logic commands. The low-side command is active low, the high-side command is active high and the stop command is active low. Two supply-fault flags are also inputs. One flag marks the main supply as low and the other marks the floating high-side supply as low. All five inputs are resynchronised into the block clock. A decoder turns them into one request: low on, high on, or none. A four-state machine then grants that request to the gates.

The machine never moves straight from one switch to the other. Each turn-off is followed by a run of cycles with both gates off. The length of that run comes from a programmable count. When the leg has already been off for at least that long, a new request is granted on the next clock, with no extra delay. The bootstrap-charge enable tracks the low-side gate. Because of this, the floating supply is charged only while the low switch conducts.

The states are ARMED (both off, dead time met), GAP (both off, dead time running), LOW_ON and HIGH_ON. The transitions are:
- ARMED to LOW_ON or HIGH_ON when a request arrives.
- LOW_ON or HIGH_ON to GAP when its request goes away.
- GAP to LOW_ON, HIGH_ON or ARMED once the count is met, depending on the request at that point.
- GAP to GAP while the count is still running.

Top module: `hb_gate_ctrl`

## Requirements
- R1: During reset and after its release, `gate_hi`, `gate_lo` and `boot_chg` are 0. The synchronisers reset to a safe value: stop asserted and both supply flags set.
- R2: With `stop_n`=1 and both supply flags 0, `lo_cmd_n`=0 with `hi_cmd`=0 requests the low side, and `lo_cmd_n`=1 with `hi_cmd`=1 requests the high side. The requested gate goes to 1 and the other gate stays 0.
- R3: `lo_cmd_n`=0 together with `hi_cmd`=1 is an interlock. Both gates are 0.
- R4: `lo_cmd_n`=1 together with `hi_cmd`=0 is no request. Both gates are 0.
- R5: `stop_n`=0 drives both gates to 0 no later than the third rising clock edge after the change. The gates stay 0 whatever the command inputs do while the stop is held.
- R6: After either gate falls, both gates stay 0 for exactly max(`dead_cycles`,1) cycles before any gate rises. This applies when the request is already waiting, including a request that arrived less than the dead time after the fall.
- R7: `dead_cycles`=0 gives exactly one cycle with both gates 0 between two on-phases.
- R8: If the leg has been off for at least the dead time, a new request reaches its gate on the third rising edge after the input change (two synchroniser stages plus the state register).
- R9: With `lo_cmd_n` and `hi_cmd` driven by one signal, a 0 selects the low side and a 1 selects the high side. Every change inserts the dead time of R6, and the two gates are never 1 together.
- R10: `uv_main`=1 drives both gates to 0.
- R11: `uv_float`=1 drives `gate_hi` to 0. It does not stop `gate_lo` from turning on.
- R12: `boot_chg` equals `gate_lo` on every cycle.
- R13: `gate_hi` and `gate_lo` are never 1 on the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lo_cmd_n | input | 1 | Low-side command, active low |
| hi_cmd | input | 1 | High-side command, active high |
| stop_n | input | 1 | Stop command, active low |
| uv_main | input | 1 | Main supply low flag, active high |
| uv_float | input | 1 | Floating supply low flag, active high |
| dead_cycles | input | DT_W | Dead time in clock cycles (0 treated as 1) |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |
| boot_chg | output | 1 | Bootstrap-charge enable |

## Verification
Suppose the state register or the gap counter held a wrong value. At the ports this would show as a gate rising one or more cycles too early or too late after a fall, or as a gate that stays on after its request is gone. A per-clock reference model catches that on the first cycle it happens. A decode fault shows up on the third edge after the input change, as the wrong gate or a missing interlock. A counter that is off by one changes the measured both-off gap. That is why the gap is checked directly for dead times of 0, 4 and 6, and for a request that arrives inside the gap.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_LOW  = 2'd1,
        REQ_HIGH = 2'd2
    } leg_req_e;

    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,
        ST_GAP     = 2'd1,
        ST_LOW_ON  = 2'd2,
        ST_HIGH_ON = 2'd3
    } leg_state_e;

    // bit positions inside the synchronised input vector
    localparam int unsigned IDX_UVF   = 0;
    localparam int unsigned IDX_UVM   = 1;
    localparam int unsigned IDX_STOP  = 2;
    localparam int unsigned IDX_HI    = 3;
    localparam int unsigned IDX_LO_N  = 4;
    localparam int unsigned N_INPUTS  = 5;

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int unsigned WIDTH  = 5,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/hb_decode.sv
module hb_decode
    import hb_pkg::*;
(
    input  logic             lo_n_s,
    input  logic             hi_s,
    input  logic             stop_n_s,
    input  logic             uv_main_s,
    input  logic             uv_float_s,
    output leg_req_e         req
);

    logic want_lo;
    logic want_hi;
    logic leg_blocked;

    always_comb begin
        want_lo     = ~lo_n_s;
        want_hi     = hi_s;
        leg_blocked = ~stop_n_s | uv_main_s;
        req         = REQ_NONE;
        if (!leg_blocked) begin
            if (want_lo && want_hi) begin
                req = REQ_NONE;            // interlock
            end else if (want_hi) begin
                req = uv_float_s ? REQ_NONE : REQ_HIGH;
            end else if (want_lo) begin
                req = REQ_LOW;
            end
        end
    end

endmodule

// File: rtl/hb_fsm.sv
module hb_fsm
    import hb_pkg::*;
#(
    parameter int unsigned DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  leg_req_e        req,
    input  logic [DT_W-1:0] dead_cycles,
    output logic            gate_hi,
    output logic            gate_lo
);

    localparam logic [DT_W-1:0] ONE = DT_W'(1);

    leg_state_e      state_q, state_d;
    logic [DT_W-1:0] gap_q, gap_d;
    logic [DT_W-1:0] dead_eff;
    logic            gap_done;

    assign dead_eff = (dead_cycles == '0) ? ONE : dead_cycles;
    assign gap_done = (gap_q >= dead_eff);

    // next state and gap counter
    always_comb begin
        state_d = state_q;
        gap_d   = '0;
        unique case (state_q)
            ST_ARMED: begin
                if (req == REQ_LOW)       state_d = ST_LOW_ON;
                else if (req == REQ_HIGH) state_d = ST_HIGH_ON;
            end
            ST_LOW_ON: begin
                if (req != REQ_LOW) begin
                    state_d = ST_GAP;
                    gap_d   = ONE;
                end
            end
            ST_HIGH_ON: begin
                if (req != REQ_HIGH) begin
                    state_d = ST_GAP;
                    gap_d   = ONE;
                end
            end
            ST_GAP: begin
                if (gap_done) begin
                    if (req == REQ_LOW)       state_d = ST_LOW_ON;
                    else if (req == REQ_HIGH) state_d = ST_HIGH_ON;
                    else                      state_d = ST_ARMED;
                end else begin
                    gap_d = gap_q + ONE;
                end
            end
            default: state_d = ST_ARMED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            gap_q   <= gap_d;
        end
    end

    // outputs
    always_comb begin
        gate_hi = 1'b0;
        gate_lo = 1'b0;
        unique case (state_q)
            ST_LOW_ON:  gate_lo = 1'b1;
            ST_HIGH_ON: gate_hi = 1'b1;
            default: ;
        endcase
    end

    // R6
    lo_to_hi_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_lo |=> !gate_hi);
    // R6
    hi_to_lo_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_hi |=> !gate_lo);
    // R2
    hi_grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi) |-> $past(req) == REQ_HIGH);

endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
    import hb_pkg::*;
#(
    parameter int unsigned DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lo_cmd_n,
    input  logic            hi_cmd,
    input  logic            stop_n,
    input  logic            uv_main,
    input  logic            uv_float,
    input  logic [DT_W-1:0] dead_cycles,
    output logic            gate_hi,
    output logic            gate_lo,
    output logic            boot_chg
);

    localparam logic [N_INPUTS-1:0] SAFE_VAL = N_INPUTS'(5'b10011);

    logic [N_INPUTS-1:0] raw_vec;
    logic [N_INPUTS-1:0] sync_vec;
    leg_req_e            req;

    assign raw_vec[IDX_LO_N] = lo_cmd_n;
    assign raw_vec[IDX_HI]   = hi_cmd;
    assign raw_vec[IDX_STOP] = stop_n;
    assign raw_vec[IDX_UVM]  = uv_main;
    assign raw_vec[IDX_UVF]  = uv_float;

    hb_sync #(
        .WIDTH  (N_INPUTS),
        .STAGES (2),
        .RST_VAL(SAFE_VAL)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_vec),
        .d_out (sync_vec)
    );

    hb_decode u_decode (
        .lo_n_s     (sync_vec[IDX_LO_N]),
        .hi_s       (sync_vec[IDX_HI]),
        .stop_n_s   (sync_vec[IDX_STOP]),
        .uv_main_s  (sync_vec[IDX_UVM]),
        .uv_float_s (sync_vec[IDX_UVF]),
        .req        (req)
    );

    hb_fsm #(.DT_W(DT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .dead_cycles (dead_cycles),
        .gate_hi     (gate_hi),
        .gate_lo     (gate_lo)
    );

    assign boot_chg = gate_lo;

    // both-off run length, used by the dead-time check
    localparam logic [DT_W-1:0] RUN_MAX = '1;
    logic [DT_W-1:0] off_run_q;
    logic [DT_W-1:0] need_gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  off_run_q <= RUN_MAX;
        else if (gate_hi || gate_lo) off_run_q <= '0;
        else if (off_run_q != RUN_MAX) off_run_q <= off_run_q + DT_W'(1);
    end

    assign need_gap = (dead_cycles == '0) ? DT_W'(1) : dead_cycles;

    // R13
    no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo));
    // R6
    dead_gap_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi) |-> off_run_q >= need_gap);
    // R6
    dead_gap_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_lo) |-> off_run_q >= need_gap);
    // R5
    stop_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_vec[IDX_STOP] |=> !gate_hi && !gate_lo);
    // R10
    uv_main_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_vec[IDX_UVM] |=> !gate_hi && !gate_lo);
    // R11
    uv_float_hi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_vec[IDX_UVF] |=> !gate_hi);

endmodule

// File: tb/hb_gate_ctrl_test.sv
module hb_gate_ctrl_test;

    localparam int DT_W = 8;
    localparam int SAFE_ARMED = 1 << 20;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            lo_cmd_n = 1'b1;
    logic            hi_cmd = 1'b0;
    logic            stop_n = 1'b0;
    logic            uv_main = 1'b1;
    logic            uv_float = 1'b1;
    logic [DT_W-1:0] dead_cycles = 8'd4;
    logic            gate_hi, gate_lo, boot_chg;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string phase = "R1";

    always #10 clk = ~clk;

    hb_gate_ctrl #(.DT_W(DT_W)) uut (
        .clk(clk), .rst_n(rst_n), .lo_cmd_n(lo_cmd_n), .hi_cmd(hi_cmd),
        .stop_n(stop_n), .uv_main(uv_main), .uv_float(uv_float),
        .dead_cycles(dead_cycles), .gate_hi(gate_hi), .gate_lo(gate_lo),
        .boot_chg(boot_chg)
    );

    // behavioural reference: input delay line plus on/off bookkeeping
    bit p1 [5];
    bit p2 [5];
    bit m_lo, m_hi;
    int off_len;

    task automatic model_reset();
        p1 = '{1, 0, 0, 1, 1};   // lo_n, hi, stop_n, uv_main, uv_float
        p2 = '{1, 0, 0, 1, 1};
        m_lo = 0; m_hi = 0; off_len = SAFE_ARMED;
    endtask

    initial model_reset();

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            int want;    // 0 none, 1 low, 2 high
            int eff;
            eff = (dead_cycles == 0) ? 1 : int'(dead_cycles);
            want = 0;
            if (p2[2] && !p2[3]) begin
                if (!p2[0] && p2[1]) want = 0;
                else if (p2[1])      want = p2[4] ? 0 : 2;
                else if (!p2[0])     want = 1;
            end
            if (m_lo) begin
                if (want != 1) begin m_lo = 0; off_len = 1; end
            end else if (m_hi) begin
                if (want != 2) begin m_hi = 0; off_len = 1; end
            end else if (off_len >= eff) begin
                if (want == 1)      m_lo = 1;
                else if (want == 2) m_hi = 1;
                else                off_len = SAFE_ARMED;
            end else begin
                off_len++;
            end
            p2 = p1;
            p1 = '{lo_cmd_n, hi_cmd, stop_n, uv_main, uv_float};
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model (R12 on boot_chg)
    always @(negedge clk) begin
        if (!done) begin
            chk({phase, " gate_hi"}, int'(gate_hi), int'(m_hi));
            chk({phase, " gate_lo"}, int'(gate_lo), int'(m_lo));
            chk("R12 boot_chg", int'(boot_chg), int'(m_lo));
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tied(bit x);
        lo_cmd_n = x;
        hi_cmd   = x;
    endtask

    // waits for the leg to go off, then counts both-off cycles
    task automatic measure_gap(output int g);
        while (gate_hi || gate_lo) @(negedge clk);
        g = 0;
        while (!gate_hi && !gate_lo) begin
            g++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        int g;
        int k;
        // R1: reset state
        idle(3);
        chk("R1 reset gate_hi", int'(gate_hi), 0);
        chk("R1 reset gate_lo", int'(gate_lo), 0);
        chk("R1 reset boot_chg", int'(boot_chg), 0);
        rst_n = 1'b1;
        idle(4);
        chk("R1 after reset gate_hi", int'(gate_hi), 0);
        chk("R1 after reset gate_lo", int'(gate_lo), 0);

        // R4: no request
        phase = "R4";
        stop_n = 1; uv_main = 0; uv_float = 0;
        lo_cmd_n = 1; hi_cmd = 0;
        idle(10);
        chk("R4 none gate_hi", int'(gate_hi), 0);
        chk("R4 none gate_lo", int'(gate_lo), 0);

        // R2 and R8: low side from a long-idle leg, three edges latency
        phase = "R2";
        lo_cmd_n = 0;
        k = 0;
        do begin @(negedge clk); k++; end while (!gate_lo && k < 20);
        chk("R8 idle latency low", k, 3);
        idle(3);
        chk("R2 low gate_lo", int'(gate_lo), 1);
        chk("R2 low gate_hi", int'(gate_hi), 0);
        chk("R12 boot with low on", int'(boot_chg), 1);

        // R3: interlock
        phase = "R3";
        hi_cmd = 1;
        idle(12);
        chk("R3 interlock gate_hi", int'(gate_hi), 0);
        chk("R3 interlock gate_lo", int'(gate_lo), 0);

        // R2: high side
        phase = "R2";
        lo_cmd_n = 1;
        idle(10);
        chk("R2 high gate_hi", int'(gate_hi), 1);
        chk("R2 high gate_lo", int'(gate_lo), 0);

        // R9 and R6: tied inputs, dead time 4
        phase = "R9";
        tied(1'b0);
        measure_gap(g);
        chk("R9 tied hi->lo gap", g, 4);
        chk("R9 tied lands low", int'(gate_lo), 1);
        idle(8);
        tied(1'b1);
        measure_gap(g);
        chk("R6 tied lo->hi gap", g, 4);
        chk("R9 tied lands high", int'(gate_hi), 1);
        idle(8);

        // R7: dead time zero means one off cycle
        phase = "R7";
        dead_cycles = 0;
        tied(1'b0);
        measure_gap(g);
        chk("R7 zero dead gap", g, 1);
        idle(6);
        tied(1'b1);
        measure_gap(g);
        chk("R7 zero dead gap back", g, 1);
        idle(6);

        // R6: request arrives inside the gap, dead time 6
        phase = "R6";
        dead_cycles = 6;
        tied(1'b0);
        idle(15);
        lo_cmd_n = 1; hi_cmd = 0;
        idle(2);
        hi_cmd = 1;
        measure_gap(g);
        chk("R6 late request gap", g, 6);
        chk("R6 late request high", int'(gate_hi), 1);

        // R8: request well after the gap, no added delay
        phase = "R8";
        hi_cmd = 0;
        idle(20);
        hi_cmd = 1;
        k = 0;
        do begin @(negedge clk); k++; end while (!gate_hi && k < 20);
        chk("R8 direct latency high", k, 3);
        idle(4);

        // R5: stop overrides everything
        phase = "R5";
        stop_n = 0;
        idle(3);
        chk("R5 stop gate_hi", int'(gate_hi), 0);
        tied(1'b0);
        idle(5);
        hi_cmd = 1;
        idle(5);
        chk("R5 stop held gate_lo", int'(gate_lo), 0);
        chk("R5 stop held gate_hi", int'(gate_hi), 0);
        stop_n = 1;
        tied(1'b0);
        idle(12);
        chk("R5 release low on", int'(gate_lo), 1);

        // R10: main supply fault
        phase = "R10";
        uv_main = 1;
        idle(3);
        chk("R10 uv_main gate_lo", int'(gate_lo), 0);
        tied(1'b1);
        idle(10);
        chk("R10 uv_main gate_hi", int'(gate_hi), 0);
        uv_main = 0;
        idle(12);
        chk("R10 release high on", int'(gate_hi), 1);

        // R11: floating supply fault
        phase = "R11";
        uv_float = 1;
        idle(3);
        chk("R11 uv_float gate_hi", int'(gate_hi), 0);
        tied(1'b0);
        idle(12);
        chk("R11 low still allowed", int'(gate_lo), 1);
        chk("R12 boot follows low", int'(boot_chg), 1);
        uv_float = 0;
        idle(4);

        finish_run();
    end

endmodule